// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital input stage of a 12-bit serial-input digital-to-analog converter. It watches three pins: an active-low frame select, a serial bit clock and a data line. The pins are asynchronous to the system clock, so the block first synchronises all three, then detects edges on the synchronised copies. A frame begins when the select line falls. Each falling edge of the bit clock that follows moves one data bit into a 16-bit shift register, most significant bit first.

When the sixteenth falling edge arrives, the assembled word is acted on. Its two top bits carry no meaning. The next two bits choose an output power state, and the low twelve bits are an unsigned output code. A one-cycle strobe marks every load. If the select line returns high before the sixteenth edge, the partial word is thrown away and nothing changes. The analog stage that follows takes the code, a drive-enable and a pull-down select from this block.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, `code` is 0, `pmode` is 00, `upd` is 0, `out_drive` is 1 and `term_sel` is 00.
- R2: A frame is opened by a falling edge of `sync_n`. The 16 `sdi` bits sampled on the next 16 falling edges of `sclk` form a word, first bit in bit 15. On the 16th edge `pmode` takes word bits 13:12, and `code` takes bits 11:0 when those mode bits are 00.
- R3: Word bits 15 and 14 have no effect on `code`, `pmode` or `upd`.
- R4: If `sync_n` rises after fewer than 16 falling `sclk` edges, the frame is dropped: `code`, `pmode` and `term_sel` keep their values and `upd` does not pulse.
- R5: A dropped frame leaves nothing behind, so the next complete frame decodes exactly as if the dropped one had not occurred.
- R6: Falling `sclk` edges after the 16th, while `sync_n` stays low, are ignored until `sync_n` rises and falls again.
- R7: `sync_n` that is low from reset onward opens no frame; `sclk` edges in that state load nothing.
- R8: The mode values drive the output controls as follows. 00 (normal) gives `out_drive`=1 and `term_sel`=00. 01 (low-value pull-down) gives `term_sel`=01. 10 (high-value pull-down) gives `term_sel`=10. 11 (floating) gives `term_sel`=00. `out_drive` is 0 for every mode other than 00.
- R9: A frame whose mode bits are not 00 updates `pmode` and leaves `code` unchanged.
- R10: `upd` is high for exactly one cycle per completed frame. That cycle is the one in which `code` and `pmode` take their new values, at the (SYNC_STAGES+1)th rising clock edge after the 16th falling `sclk` edge appears at the pin.
- R11: A rise of `sync_n` seen in the same sampled cycle as the 16th falling `sclk` edge still completes the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame select pin |
| sclk | input | 1 | Serial bit clock pin; data taken on its falling edge |
| sdi | input | 1 | Serial data pin |
| code | output | CODE_W | Output code register |
| pmode | output | 2 | Power mode register |
| upd | output | 1 | One-cycle strobe when the registers are loaded |
| out_drive | output | 1 | Output amplifier enable (normal mode) |
| term_sel | output | 2 | Pull-down select: bit 0 low-value, bit 1 high-value |

## Verification
The case that matters most is when frame completion and frame abort fall in the same cycle. This happens when the sixteenth falling bit-clock edge and the rising select line reach the synchronised domain together. The bench provokes it by changing both pins at the same clock edge, both in a directed case and at random. It judges the result by requiring a normal load with exactly one strobe, never a discard. A separate directed case counts clock edges from the sixteenth bit-clock fall to the strobe.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   typedef enum logic [1:0] {
      PM_ACTIVE   = 2'b00,
      PM_PULL_LOW = 2'b01,
      PM_PULL_WEAK = 2'b10,
      PM_OPEN     = 2'b11
   } pmode_e;

   localparam int unsigned MODE_W = 2;

   // pull-down select for a given mode: bit0 strong path, bit1 weak path
   function automatic logic [1:0] term_of(input pmode_e m);
      case (m)
         PM_PULL_LOW:  term_of = 2'b01;
         PM_PULL_WEAK: term_of = 2'b10;
         default:      term_of = 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/sdac_sync_chain.sv
module sdac_sync_chain #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("sdac_sync_chain: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift #(
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_lvl,   // synchronised active-low select
   input  logic               bclk_lvl,  // synchronised bit clock
   input  logic               bit_lvl,   // synchronised data
   output logic               done,
   output logic [FRAME_W-1:0] word
);

   localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("sdac_frame_shift: FRAME_W must be at least 2");
   end

   logic               sel_prev, bclk_prev;
   logic               armed;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] shreg;

   logic sel_fell, sel_rose, bclk_fell, take, last;
   logic [FRAME_W-1:0] word_nxt;

   always_comb begin
      sel_fell  = sel_prev & ~sel_lvl;
      sel_rose  = ~sel_prev & sel_lvl;
      bclk_fell = bclk_prev & ~bclk_lvl;
      take      = armed & bclk_fell & ~sel_fell;
      last      = take & (cnt == LAST_IDX);
      word_nxt  = {shreg[FRAME_W-2:0], bit_lvl};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev  <= 1'b0;
         bclk_prev <= 1'b0;
      end else begin
         sel_prev  <= sel_lvl;
         bclk_prev <= bclk_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
      end else if (sel_fell) begin
         armed <= 1'b1;
         cnt   <= '0;
         shreg <= '0;
      end else begin
         if (take) begin
            shreg <= word_nxt;
            cnt   <= cnt + 1'b1;
         end
         // completion outranks a select rise seen in the same cycle
         if (last) begin
            armed <= 1'b0;
         end else if (sel_rose && armed) begin
            armed <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
         end
      end
   end

   assign done = last;
   assign word = word_nxt;

endmodule

// File: rtl/sdac_out_regs.sv
module sdac_out_regs
   import sdac_pkg::*;
#(
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done,
   input  logic [FRAME_W-1:0] word,
   output logic [CODE_W-1:0]  code,
   output logic [MODE_W-1:0]  pmode,
   output logic               upd,
   output logic               out_drive,
   output logic [1:0]         term_sel
);

   localparam int unsigned MODE_LSB = CODE_W;
   localparam int unsigned USED_W   = CODE_W + MODE_W;

   if (FRAME_W < USED_W) begin : g_bad_fields
      $error("sdac_out_regs: FRAME_W too small for code and mode fields");
   end

   pmode_e new_mode, cur_mode;

   assign new_mode = pmode_e'(word[MODE_LSB +: MODE_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code     <= '0;
         cur_mode <= PM_ACTIVE;
         upd      <= 1'b0;
      end else begin
         upd <= done;
         if (done) begin
            cur_mode <= new_mode;
            if (new_mode == PM_ACTIVE) code <= word[CODE_W-1:0];
         end
      end
   end

   assign pmode     = cur_mode;
   assign out_drive = (cur_mode == PM_ACTIVE);
   assign term_sel  = term_of(cur_mode);

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
   parameter int unsigned CODE_W      = 12,
   parameter int unsigned FRAME_W     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [CODE_W-1:0] code,
   output logic [1:0]        pmode,
   output logic              upd,
   output logic              out_drive,
   output logic [1:0]        term_sel
);

   localparam int unsigned PIN_W = 3;

   if (CODE_W < 1) begin : g_bad_code
      $error("sdac_frame_rx: CODE_W must be at least 1");
   end

   logic [PIN_W-1:0]   pins_q;
   logic               done;
   logic [FRAME_W-1:0] word;

   sdac_sync_chain #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sync_n, sclk, sdi}),
      .q     (pins_q)
   );

   sdac_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_lvl  (pins_q[2]),
      .bclk_lvl (pins_q[1]),
      .bit_lvl  (pins_q[0]),
      .done     (done),
      .word     (word)
   );

   sdac_out_regs #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .word      (word),
      .code      (code),
      .pmode     (pmode),
      .upd       (upd),
      .out_drive (out_drive),
      .term_sel  (term_sel)
   );

endmodule

// File: rtl/sdac_frame_rx_chk.sv
module sdac_frame_rx_chk #(
   parameter int unsigned CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code,
   input logic [1:0]        pmode,
   input logic              upd,
   input logic              out_drive,
   input logic [1:0]        term_sel
);

   // R10
   upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> !upd);

   // R10
   code_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code != $past(code)) |-> upd);

   // R10
   mode_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode != $past(pmode)) |-> upd);

   // R9
   pd_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && pmode != 2'b00) |-> (code == $past(code)));

   // R8
   term_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(term_sel));

   // R8
   drive_no_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_drive |-> (term_sel == 2'b00));

endmodule

bind sdac_frame_rx sdac_frame_rx_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .code      (code),
   .pmode     (pmode),
   .upd       (upd),
   .out_drive (out_drive),
   .term_sel  (term_sel)
);

// File: tb/sdac_frame_rx_tb.sv
`timescale 1ns/1ps
module sdac_frame_rx_tb;

   localparam int CODE_W = 12;
   localparam int SYNC_STAGES = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_n = 1'b0;
   logic sclk = 1'b1;
   logic sdi = 1'b0;
   logic [CODE_W-1:0] code;
   logic [1:0] pmode;
   logic upd, out_drive;
   logic [1:0] term_sel;

   int total = 0;
   int bad = 0;
   int n_upd = 0;
   int exp_upd = 0;
   logic [CODE_W-1:0] exp_code = '0;
   logic [1:0] exp_mode = 2'b00;

   always #4 clk = ~clk;

   sdac_frame_rx #(.CODE_W(CODE_W), .FRAME_W(16), .SYNC_STAGES(SYNC_STAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
      .code(code), .pmode(pmode), .upd(upd), .out_drive(out_drive), .term_sel(term_sel)
   );

   always @(negedge clk) if (rst_n && upd) n_upd++;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] term_for(input logic [1:0] m);
      return (m == 2'b01) ? 2'b01 : (m == 2'b10) ? 2'b10 : 2'b00;
   endfunction

   task automatic model(input logic [15:0] w);
      exp_mode = w[13:12];
      if (w[13:12] == 2'b00) exp_code = w[11:0];
      exp_upd++;
   endtask

   task automatic check_all(input string req);
      check({req, " code"}, int'(code), int'(exp_code));
      check({req, " mode"}, int'(pmode), int'(exp_mode));
      check({req, " drive"}, int'(out_drive), int'(exp_mode == 2'b00));
      check({req, " term"}, int'(term_sel), int'(term_for(exp_mode)));
      check({req, " strobes"}, n_upd, exp_upd);
   endtask

   task automatic phase();
      repeat (3) @(negedge clk);
   endtask

   task automatic send(input logic [15:0] w, input int nbits, input int extra, input bit together);
      sync_n = 1'b1; sclk = 1'b1; phase();
      sync_n = 1'b0; phase();
      for (int i = 0; i < nbits; i++) begin
         sdi = w[15-i]; sclk = 1'b1; phase();
         if (together && i == nbits - 1) begin
            sclk = 1'b0; sync_n = 1'b1; phase();
         end else begin
            sclk = 1'b0; phase();
         end
      end
      for (int e = 0; e < extra; e++) begin
         sdi = ~sdi; sclk = 1'b1; phase();
         sclk = 1'b0; phase();
      end
      sclk = 1'b1; phase();
      sync_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5eed_0c0d));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 code", int'(code), 0);
      check("R1 mode", int'(pmode), 0);
      check("R1 upd", int'(upd), 0);
      check("R1 drive", int'(out_drive), 1);
      check("R1 term", int'(term_sel), 0);

      // R7: select low since reset, clock 16 bits, nothing loads
      for (int i = 0; i < 16; i++) begin
         sdi = 1'b1; sclk = 1'b1; phase();
         sclk = 1'b0; phase();
      end
      sclk = 1'b1; phase();
      check_all("R7");

      // R2 basic frame
      send(16'h0A5C, 16, 0, 1'b0); model(16'h0A5C); check_all("R2");
      // R3 don't-care top bits
      send(16'hCA5C, 16, 0, 1'b0); model(16'hCA5C); check_all("R3");
      send(16'h4123, 16, 0, 1'b0); model(16'h4123); check_all("R3 b14");
      // R4 abort after 15 bits
      send(16'h0FFF, 15, 0, 1'b0); check_all("R4");
      // R5 next frame after abort is clean
      send(16'h0001, 16, 0, 1'b0); model(16'h0001); check_all("R5");
      // R6 extra edges ignored
      send(16'h0800, 16, 7, 1'b0); model(16'h0800); check_all("R6");
      // R8/R9 each power-down mode keeps code
      send(16'h1FFF, 16, 0, 1'b0); model(16'h1FFF); check_all("R8 R9 m01");
      send(16'h2AAA, 16, 0, 1'b0); model(16'h2AAA); check_all("R8 R9 m10");
      send(16'h3555, 16, 0, 1'b0); model(16'h3555); check_all("R8 R9 m11");
      send(16'h0777, 16, 0, 1'b0); model(16'h0777); check_all("R8 m00");
      // R11 select rise with the 16th edge
      send(16'h0C3C, 16, 0, 1'b1); model(16'h0C3C); check_all("R11");

      // R10 directed latency
      begin
         logic [15:0] w = 16'h0ABC;
         sync_n = 1'b1; sclk = 1'b1; phase();
         sync_n = 1'b0; phase();
         for (int i = 0; i < 16; i++) begin
            sdi = w[15-i]; sclk = 1'b1; phase();
            sclk = 1'b0;
            if (i < 15) phase();
         end
         repeat (SYNC_STAGES) @(posedge clk);
         @(negedge clk);
         check("R10 early upd", int'(upd), 0);
         check("R10 early code", int'(code), int'(exp_code));
         @(posedge clk); @(negedge clk);
         model(w);
         check("R10 upd", int'(upd), 1);
         check("R10 code", int'(code), int'(exp_code));
         @(negedge clk);
         check("R10 upd low", int'(upd), 0);
         sclk = 1'b1; phase();
         sync_n = 1'b1; repeat (6) @(negedge clk);
         check_all("R10 after");
      end

      // random mix
      for (int it = 0; it < 60; it++) begin
         logic [15:0] w = 16'($urandom);
         int kind = int'($urandom % 4);
         case (kind)
            0: begin send(w, 16, 0, 1'b0); model(w); check_all("R2 rnd"); end
            1: begin send(w, int'($urandom % 16), 0, 1'b0); check_all("R4 rnd"); end
            2: begin send(w, 16, 1 + int'($urandom % 5), 1'b0); model(w); check_all("R6 rnd"); end
            default: begin send(w, 16, 0, 1'b1); model(w); check_all("R11 rnd"); end
         endcase
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule